// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Line Filler

This block loads one 16-word cache line after a miss. It accepts the miss address through a valid/ready request port and clears the four low address bits, so the fill always starts on a line boundary. For exactly one cycle it drives that aligned address on the shared one-word bus. It then starts four independent one-word-wide memory banks, one cycle apart. Word offsets are spread across the banks by the two low offset bits, so bank fetches overlap with bus transfers.

Each bank takes a fixed eight cycles per fetch and makes four fetches per line. A bank receives its next address in the same bus cycle that carries its previous word, so the words reach the cache write port in ascending order. The write port gives a strobe, a word index and the data. A CPU stall output stays high from the address cycle through the bus cycle of the final word. The block is idle again on the next cycle.

Request port rules: `miss_ready` is high only while the block is idle. A request is taken in a cycle where both `miss_valid` and `miss_ready` are high. While a fill is in progress, `miss_ready` is low and any presented request has no effect. A requester may hold `miss_valid` and its address until the request is taken. The cache write port has no back-pressure: the cache must take every word in the cycle its strobe is high.

Top module: `line_filler`

## Requirements
- R1: `miss_ready` is high exactly when no fill is in progress. A request is accepted on a cycle with `miss_valid` and `miss_ready` both high. A request presented during a fill has no effect on the data or timing of that fill.
- R2: In the cycle after acceptance (cycle 1), `addr_valid` is high for that single cycle. `addr_out` equals the request address with its low 4 bits cleared. No bank is fetching in that cycle.
- R3: A bank fetch lasts 8 cycles, and the bank address register stays constant for the whole fetch.
- R4: Line word offset k comes from bank k mod 4. The write index `wr_idx` equals k.
- R5: At most one bank drives the bus in any cycle, and each bus cycle carries one word.
- R6: Counting the address cycle as cycle 1, word k is written in cycle 10 + (k mod 4) + 8*(k div 4). The sixteen words arrive in ascending order, and the last one arrives in cycle 37.
- R7: `stall` is low in the acceptance cycle and high in cycles 1 through 37, which gives a miss penalty of 37 cycles.
- R8: In the cycle after the sixteenth word (cycle 38), `stall` is low and `miss_ready` is high.
- R9: The bank contents after reset are defined by the word address a (line base * 16 + offset). Each word is the low DATA_W bits of (a * 0x9E3779B1) XOR 0x5A5AC3C3, computed in 32-bit arithmetic. The written data equals this value.
- R10: A synchronous active-high `rst` clears all bank pipelines, the word counter and `stall`. After a reset in mid-fill, no word is written and `miss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Filler can accept a request |
| miss_addr | input | ADDR_W | Word address of the missing access |
| addr_valid | output | 1 | Aligned line address is on the bus this cycle |
| addr_out | output | ADDR_W | Aligned line address |
| wr_valid | output | 1 | Cache word write strobe |
| wr_idx | output | 4 | Word offset within the line |
| wr_data | output | DATA_W | Word written into the cache |
| stall | output | 1 | CPU stall while the line is loading |

## Verification
The assertions check the following on every cycle: a bank address does not change during a fetch, at most one bank drives the bus, the written index selects the bank that is driving, no bank fetches during the address cycle, and the block releases on the cycle after the last word. Only the bench scenarios can show the cycle-exact arrival schedule, the data values, the 37-cycle stall window, that a request held during a fill is ignored, and the recovery after a reset in mid-fill. These scenarios use random line addresses and directed cases at the top and bottom of the address space.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {LF_IDLE, LF_ADDR, LF_FILL} lf_state_e;

  // Deterministic content of the behavioural banks, keyed by word address.
  function automatic logic [31:0] lf_pattern(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction
endpackage

// File: rtl/lf_bank.sv
module lf_bank #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NBANK   = 4,
  parameter int LINE_W  = 16,
  parameter int LAT     = 8,
  parameter int BANK_ID = 0
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              start,
  input  logic [ADDR_W-$clog2(LINE_W)-1:0]                  line_base,
  output logic                                              rdy,
  output logic [DATA_W-1:0]                                 rd_data,
  output logic                                              busy
);
  import lf_pkg::*;

  localparam int BSEL_W = $clog2(NBANK);
  localparam int FPB    = LINE_W / NBANK;
  localparam int FSEL_W = $clog2(FPB);
  localparam int BA_W   = ADDR_W - BSEL_W;
  localparam int DEPTH  = 2 ** BA_W;
  localparam int CNT_W  = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BA_W-1:0]   addr_q;
  logic [CNT_W-1:0]  cnt;
  logic [FSEL_W-1:0] fidx;
  logic [DATA_W-1:0] rd_q;
  logic              rdy_q;
  logic              done;
  logic              rearm;

  assign done  = (cnt == CNT_W'(1));
  assign rearm = done && (fidx != FSEL_W'(FPB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DATA_W'(lf_pattern(32'((i * NBANK) + BANK_ID)));
      end
      addr_q <= '0;
      cnt    <= '0;
      fidx   <= '0;
      rd_q   <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= done;
      if (done) rd_q <= mem[addr_q];
      if (start) begin
        addr_q <= {line_base, {FSEL_W{1'b0}}};
        fidx   <= '0;
        cnt    <= CNT_W'(LAT);
      end else if (rearm) begin
        addr_q <= addr_q + BA_W'(1);
        fidx   <= fidx + FSEL_W'(1);
        cnt    <= CNT_W'(LAT);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign rdy     = rdy_q;
  assign rd_data = rd_q;
  assign busy    = (cnt != '0);

  // R3: bank address held for the whole fetch
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt > CNT_W'(1)) |=> $stable(addr_q));
  // R3: a new line only starts on an idle bank
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt == '0));
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl #(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4,
  parameter int LINE_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              miss_valid,
  input  logic [ADDR_W-1:0]                 miss_addr,
  output logic                              miss_ready,
  input  logic                              wr_valid,
  output logic [$clog2(LINE_W)-1:0]         wr_idx,
  output logic [NBANK-1:0]                  kick,
  output logic [ADDR_W-$clog2(LINE_W)-1:0]  line_base,
  output logic                              addr_valid,
  output logic                              stall
);
  import lf_pkg::*;

  localparam int LSEL_W = $clog2(LINE_W);
  localparam int LB_W   = ADDR_W - LSEL_W;
  localparam int KD_W   = NBANK - 1;

  lf_state_e         state;
  logic [LB_W-1:0]   base_q;
  logic [LSEL_W-1:0] nwr;
  logic [KD_W-1:0]   kd;
  logic              accept;
  logic              last_word;

  assign accept    = miss_valid && (state == LF_IDLE);
  assign last_word = wr_valid && (nwr == LSEL_W'(LINE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= LF_IDLE;
      base_q <= '0;
      nwr    <= '0;
      kd     <= '0;
    end else begin
      kd <= KD_W'({kd, state == LF_ADDR});
      unique case (state)
        LF_IDLE: if (accept) begin
          state  <= LF_ADDR;
          base_q <= LB_W'(miss_addr >> LSEL_W);
          nwr    <= '0;
        end
        LF_ADDR: state <= LF_FILL;
        LF_FILL: begin
          if (wr_valid) nwr <= nwr + LSEL_W'(1);
          if (last_word) state <= LF_IDLE;
        end
        default: state <= LF_IDLE;
      endcase
    end
  end

  assign miss_ready = (state == LF_IDLE);
  assign stall      = (state != LF_IDLE);
  assign addr_valid = (state == LF_ADDR);
  assign kick       = {kd, state == LF_ADDR};
  assign line_base  = base_q;
  assign wr_idx     = nwr;

  // R2: address occupies the bus for exactly one cycle
  assert_addr_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid);
  // R8: release on the cycle after the last word
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == LSEL_W'(LINE_W - 1)) |=> (!stall && miss_ready));
  // R1: requests are not taken during a fill
  assert_hold_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (stall && !last_word) |=> !miss_ready);
endmodule

// File: rtl/line_filler.sv
module line_filler #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4,
  parameter int LINE_W = 16,
  parameter int LAT    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      miss_valid,
  output logic                      miss_ready,
  input  logic [ADDR_W-1:0]         miss_addr,
  output logic                      addr_valid,
  output logic [ADDR_W-1:0]         addr_out,
  output logic                      wr_valid,
  output logic [$clog2(LINE_W)-1:0] wr_idx,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      stall
);
  localparam int LSEL_W = $clog2(LINE_W);
  localparam int LB_W   = ADDR_W - LSEL_W;
  localparam int BSEL_W = $clog2(NBANK);

  logic [NBANK-1:0]  kick;
  logic [NBANK-1:0]  rdy_v;
  logic [NBANK-1:0]  busy_v;
  logic [DATA_W-1:0] bank_data [NBANK];
  logic [LB_W-1:0]   line_base;

  lf_ctrl #(.ADDR_W(ADDR_W), .NBANK(NBANK), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .kick(kick), .line_base(line_base), .addr_valid(addr_valid), .stall(stall)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lf_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBANK(NBANK), .LINE_W(LINE_W),
              .LAT(LAT), .BANK_ID(b)) u_bank (
      .clk(clk), .rst(rst), .start(kick[b]), .line_base(line_base),
      .rdy(rdy_v[b]), .rd_data(bank_data[b]), .busy(busy_v[b])
    );
  end

  // Shared one-word bus: the single ready bank drives it.
  always_comb begin
    wr_data = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rdy_v[b]) wr_data = wr_data | bank_data[b];
    end
  end

  assign wr_valid = |rdy_v;
  assign addr_out = {line_base, {LSEL_W{1'b0}}};

  // R5: one bank on the bus at a time
  assert_bus_single_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdy_v));
  // R4: written offset matches the interleaved bank on the bus
  assert_idx_bank_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> rdy_v[wr_idx[BSEL_W-1:0]]);
  // R2: no bank fetch during the address cycle
  assert_no_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (busy_v == '0));
endmodule

// File: tb/line_filler_test.sv
module line_filler_test;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              miss_valid = 1'b0;
  logic              miss_ready;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic              addr_valid;
  logic [ADDR_W-1:0] addr_out;
  logic              wr_valid;
  logic [3:0]        wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              stall;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  line_filler uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .addr_valid(addr_valid), .addr_out(addr_out),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .stall(stall)
  );

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E3779B1;
    return p ^ 32'h5A5AC3C3;
  endfunction

  function automatic int exp_cycle(input int k);
    return 10 + (k % 4) + 8 * (k / 4);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a, input bit hold_other);
    int base, nw, sc;
    bit ready_seen;
    base = int'(a) & 32'hF0;
    nw = 0; sc = 0; ready_seen = 0;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    check(miss_ready && !stall, "R7 idle before accept", {stall, miss_ready}, 1);
    @(posedge clk);
    for (int c = 1; c <= 38; c++) begin
      @(negedge clk);
      if (c == 1) begin
        check(addr_valid && addr_out == ADDR_W'(base), "R2 address cycle", addr_out, base);
        if (hold_other) miss_addr = ~a; else miss_valid = 1'b0;
      end
      if (c == 2) check(!addr_valid, "R2 single address cycle", addr_valid, 0);
      if (c == 36) miss_valid = 1'b0;
      if (wr_valid) begin
        check(c == exp_cycle(nw), "R6 word arrival cycle", c, exp_cycle(nw));
        check(wr_idx == 4'(nw), "R4 word index", wr_idx, nw);
        check(wr_data == exp_word(base + nw), "R9 word data", wr_data, exp_word(base + nw));
        nw++;
      end
      if (c <= 37) begin
        if (stall) sc++;
        if (miss_ready) ready_seen = 1;
      end
      if (c == 38) check(!stall && miss_ready, "R8 idle after last word", {stall, miss_ready}, 1);
    end
    check(nw == 16, "R5 sixteen words", nw, 16);
    check(sc == 37, "R7 stall length", sc, 37);
    check(!ready_seen, "R1 not ready during fill", ready_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ra;
    void'($urandom(32'd4099));
    repeat (3) @(negedge clk);
    check(!stall && !wr_valid, "R10 reset state", {stall, wr_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready && !stall && !wr_valid, "R10 idle after reset", miss_ready, 1);
    // directed corners: lowest line, highest line, unaligned
    do_fill(8'h00, 1'b0);
    do_fill(8'hFF, 1'b0);
    do_fill(8'h37, 1'b1);  // R1: request held during the fill is ignored
    // back-to-back random fills
    for (int n = 0; n < 12; n++) begin
      ra = ADDR_W'($urandom);
      do_fill(ra, n[0]);
    end
    // R10: reset in mid-fill
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 8'h52;
    @(posedge clk);
    miss_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    begin
      int wr_seen, st_seen, nr_seen;
      wr_seen = 0; st_seen = 0; nr_seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (wr_valid) wr_seen++;
        if (stall) st_seen++;
        if (!miss_ready) nr_seen++;
      end
      check(wr_seen == 0, "R10 no writes after mid-fill reset", wr_seen, 0);
      check(st_seen == 0 && nr_seen == 0, "R10 idle after mid-fill reset", st_seen + nr_seen, 0);
    end
    do_fill(8'hA4, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule